// File: doc/BRIEF.md
# Carrier-Loss Change Interrupt

This block monitors the carrier-detect line from a modem and tells the processor each time the carrier comes or goes. The line is active low: a high level means carrier lost and a low level means carrier present. The line is asynchronous, so it first passes through a synchroniser. The synchronised level is then compared with a latched copy. A mismatch raises an active-low interrupt and updates the latched copy, which is reported in one bit of a status byte slice.

After one change is flagged, the block locks out further events. During lockout, the interrupt and the status bit both ignore the line. A status read services the event. At that read the block compares the live level with the latched one. If they still match, it re-arms and drops the interrupt. If they differ, it takes the new level and keeps the interrupt asserted. While carrier is lost, a hold output stops the receive-data interrupts of the serial receiver.

After reset the block primes itself: for a few cycles the latched copy tracks the synchronised pin, so that whatever level the pin has at start-up does not count as an event.

Top module: `cd_irq_top`

## Requirements
- R1: During reset `irq_no` is 1 and the latched bit is 1. After reset, the latched bit settles to the pin level and no interrupt is raised, whatever that level is.
- R2: When armed, a change of `cd_loss_i` in either direction is handled three rising edges after the change: `irq_no` goes low and the latched bit takes the new level.
- R3: While an event is pending, further transitions of `cd_loss_i` change neither `irq_no` nor the latched bit until a status read.
- R4: A status read while an event is pending, with the synchronised level equal to the latched bit, returns `irq_no` to 1 on the next edge.
- R5: A status read while an event is pending, with the synchronised level different from the latched bit, keeps `irq_no` low and loads the new level into the latched bit.
- R6: `stat_o` carries the latched bit at position 5 (`LOSS_BIT`), and every other bit of `stat_o` is 0.
- R7: `rx_hold_o` follows `cd_loss_i` two rising edges later.
- R8: A status read while no event is pending leaves `irq_no` high and the latched bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cd_loss_i | input | 1 | Asynchronous carrier-detect line, 1 = carrier lost |
| stat_rd_i | input | 1 | One-cycle strobe marking a processor status read |
| stat_o | output | STAT_W (8) | Status slice, latched carrier bit at LOSS_BIT |
| irq_no | output | 1 | Interrupt request, active low |
| rx_hold_o | output | 1 | Stops receive-data interrupts while carrier is lost |

## Verification
The hardest case to reach is a status read that finds the line moved again during lockout. The line must change, change back or change further while the event is pending, and then the read must arrive with the synchronised level already settled. The vector table builds this up step by step. It first drives a change and then the opposite change under lockout, then reads to check the re-arm. Later it drives a change, reverses it under lockout and reads once to check the kept interrupt, then reads again to check the release.

// File: rtl/cd_pkg.sv
`timescale 1ns/1ps
package cd_pkg;
  typedef enum logic [1:0] {
    CD_PRIME  = 2'd0,
    CD_ARMED  = 2'd1,
    CD_LOCKED = 2'd2
  } cd_state_e;

  // edges needed until the synchroniser output reflects the pin, plus one to capture it
  function automatic int unsigned prime_len(input int unsigned stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/cd_sync.sv
`timescale 1ns/1ps
module cd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= RST_VAL;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= RST_VAL;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cd_prime.sv
`timescale 1ns/1ps
module cd_prime #(
  parameter int unsigned LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cd_event.sv
`timescale 1ns/1ps
module cd_event
  import cd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  logic      primed_i,
  input  logic      rd_i,
  output logic      held_o,
  output logic      pend_o,
  output logic      armed_o
);
  cd_state_e state_q, state_d;
  logic      held_q, held_d;

  always_comb begin
    state_d = state_q;
    held_d  = held_q;
    unique case (state_q)
      CD_PRIME: begin
        held_d = lvl_i;
        if (primed_i) state_d = CD_ARMED;
      end
      CD_ARMED: begin
        if (lvl_i != held_q) begin
          held_d  = lvl_i;
          state_d = CD_LOCKED;
        end
      end
      CD_LOCKED: begin
        // serviced by a read: re-compare live level against the latch
        if (rd_i) begin
          if (lvl_i != held_q) held_d  = lvl_i;
          else                 state_d = CD_ARMED;
        end
      end
      default: state_d = CD_PRIME;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CD_PRIME;
      held_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      held_q  <= held_d;
    end
  end

  assign held_o  = held_q;
  assign pend_o  = (state_q == CD_LOCKED);
  assign armed_o = (state_q == CD_ARMED);
endmodule

// File: rtl/cd_irq_top.sv
`timescale 1ns/1ps
module cd_irq_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAT_W      = 8,
  parameter int unsigned LOSS_BIT    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cd_loss_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_no,
  output logic              rx_hold_o
);
  localparam int unsigned PRIME_LEN = cd_pkg::prime_len(SYNC_STAGES);

  logic sync_lvl;
  logic primed;
  logic held;
  logic pend;
  logic armed;

  cd_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cd_loss_i),
    .q_o   (sync_lvl)
  );

  cd_prime #(
    .LEN(PRIME_LEN)
  ) u_prime (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(primed)
  );

  cd_event u_event (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (sync_lvl),
    .primed_i(primed),
    .rd_i    (stat_rd_i),
    .held_o  (held),
    .pend_o  (pend),
    .armed_o (armed)
  );

  always_comb begin
    stat_o           = '0;
    stat_o[LOSS_BIT] = held;
  end

  assign irq_no    = ~pend;
  assign rx_hold_o = sync_lvl;
endmodule

// File: rtl/cd_irq_chk.sv
`timescale 1ns/1ps
module cd_irq_chk #(
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned LOSS_BIT = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stat_rd_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              irq_no,
  input logic              sync_lvl,
  input logic              armed
);
  logic bit_q;
  assign bit_q = stat_o[LOSS_BIT];

  // R2
  a_r2_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && sync_lvl != bit_q) |=> (!irq_no && bit_q == $past(sync_lvl)));

  // R3
  a_r3_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !stat_rd_i) |=> (!irq_no && $stable(bit_q)));

  // R4
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && stat_rd_i && sync_lvl == bit_q) |=> irq_no);

  // R5
  a_r5_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && stat_rd_i && sync_lvl != bit_q) |=> (!irq_no && bit_q == $past(sync_lvl)));

  // R8
  a_r8_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && sync_lvl == bit_q) |=> (irq_no && $stable(bit_q)));

  // R1: no interrupt before arming
  a_r1_prime_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_no && !armed) |=> (irq_no || $past(!armed && irq_no && stat_rd_i) == 1'b0));
endmodule

bind cd_irq_top cd_irq_chk #(
  .STAT_W  (STAT_W),
  .LOSS_BIT(LOSS_BIT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stat_rd_i(stat_rd_i),
  .stat_o   (stat_o),
  .irq_no   (irq_no),
  .sync_lvl (sync_lvl),
  .armed    (armed)
);

// File: tb/test_cd_irq_top.sv
`timescale 1ns/1ps
module test_cd_irq_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cd_loss_i = 1'b1;
  logic       stat_rd_i = 1'b0;
  logic [7:0] stat_o;
  logic       irq_no;
  logic       rx_hold_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cd_irq_top i_cd_irq_top (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cd_loss_i(cd_loss_i),
    .stat_rd_i(stat_rd_i),
    .stat_o   (stat_o),
    .irq_no   (irq_no),
    .rx_hold_o(rx_hold_o)
  );

  typedef struct packed {
    logic pin;
    logic rd;
    logic irq_n;
    logic lbit;
    logic hold;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // drive one step, drop the strobe, then let the synchroniser settle
  task automatic step(input logic pin, input logic rd);
    @(negedge clk_i);
    cd_loss_i = pin;
    stat_rd_i = rd;
    @(negedge clk_i);
    stat_rd_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset with carrier present
    cd_loss_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 irq in reset", {7'd0, irq_no}, 8'd1);
    chk("R1 stat in reset", stat_o, 8'h20);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R1 irq after prime (pin low)", {7'd0, irq_no}, 8'd1);
    chk("R1 R6 stat after prime (pin low)", stat_o, 8'h00);

    // R7: hold latency two edges
    cd_loss_i = 1'b1;
    @(negedge clk_i);
    chk("R7 hold after 1 edge", {7'd0, rx_hold_o}, 8'd0);
    @(negedge clk_i);
    chk("R7 hold after 2 edges", {7'd0, rx_hold_o}, 8'd1);
    chk("R2 irq not yet at 2 edges", {7'd0, irq_no}, 8'd1);
    @(negedge clk_i);
    chk("R2 irq at 3 edges", {7'd0, irq_no}, 8'd0);
    chk("R2 R6 stat at 3 edges", stat_o, 8'h20);

    // R1: reset with carrier lost, then vector table
    rst_ni = 1'b0;
    cd_loss_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R1 irq after prime (pin high)", {7'd0, irq_no}, 8'd1);
    chk("R1 stat after prime (pin high)", stat_o, 8'h20);

    for (int i = 0; i < NV; i++) begin
      string tag;
      step(VEC[i].pin, VEC[i].rd);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      chk({tag, " irq"}, {7'd0, irq_no}, {7'd0, VEC[i].irq_n});
      chk({tag, " bit"}, {7'd0, stat_o[5]}, {7'd0, VEC[i].lbit});
      chk({tag, " R7 hold"}, {7'd0, rx_hold_o}, {7'd0, VEC[i].hold});
      chk({tag, " R6 other bits"}, stat_o & 8'hDF, 8'h00);
    end

    // R3: several toggles under lockout, then R4 release
    step(1'b1, 1'b0);
    chk("R2 raise before toggles", {7'd0, irq_no}, 8'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      cd_loss_i = ~cd_loss_i;
    end
    repeat (4) @(negedge clk_i);
    chk("R3 irq under toggles", {7'd0, irq_no}, 8'd0);
    chk("R3 bit under toggles", stat_o, 8'h20);
    step(1'b1, 1'b1);
    chk("R4 release after toggles", {7'd0, irq_no}, 8'd1);
    chk("R8 bit after release", stat_o, 8'h20);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule